// File: doc/BRIEF.md
# Vector Length and Lane Sequencer

This block runs element-wise vector additions on a small set of internal vector registers. Software first sends a configure command carrying the element count it wants and an element width code. The block limits that count to what one register can hold at that width, keeps the result as the active vector length, and shows it on `grant_vl`. An add command then names a destination and two source registers. The block walks the active elements in groups of `LANES`, one element per lane per cycle, and writes each wrapped sum back into the destination.

The command format does not carry the number of physical lanes. The same configure-then-add sequence gives the same register contents for any legal `LANES`; only the number of busy cycles changes. A side port preloads register words and reads them back, so a host can place operands and inspect results. Loads from memory, masking and instruction decode live outside this block.

Top module: `vls_seq_top`

## Requirements
- R1: A configure command (`cmd_op`=0) sets the active length to min(`cmd_avl`, VLEN/SEW), where `cmd_sew` 0, 1 and 2 select SEW = 8, 16 and 32 bits. The new length shows on `grant_vl` from the acceptance edge onward and holds until the next accepted configure.
- R2: The width code 3 is reserved. A configure with it grants a length of zero.
- R3: An add command (`cmd_op`=1) sets each destination element i below the active length to (vs1[i] + vs2[i]) mod 2^SEW. Element i occupies register bits [i*SEW +: SEW], and no carry passes between elements.
- R4: Destination elements at or above the active length keep their previous contents, including lanes of a partial last group.
- R5: An add with a nonzero length raises `done` ceil(length/LANES) clock edges after its acceptance edge. A configure, or an add with length zero, raises `done` at the acceptance edge itself.
- R6: An add with length zero writes no register.
- R7: `done` is high for exactly one cycle per completed command.
- R8: `cmd_ready` is low while an add is running. A command presented then is ignored, and `grant_vl` is unchanged.
- R9: A host write sets word j of a register (bits [j*32 +: 32]) at the clock edge while the block is idle. A host write while an add runs is ignored. The read port returns the addressed word combinationally.
- R10: After reset, `cmd_ready` is 1, `done` is 0, `grant_vl` is 0 and every register word reads zero.
- R11: A command presented in the cycle where `done` is high is accepted at the next edge.
- R12: For the same commands and operands, register contents after an add are identical for different `LANES` values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 1 | 0 configure, 1 add |
| cmd_avl | input | AVLW | Requested element count |
| cmd_sew | input | 2 | Element width code |
| cmd_vd | input | RIDXW | Destination register of an add |
| cmd_vs1 | input | RIDXW | First source register |
| cmd_vs2 | input | RIDXW | Second source register |
| cmd_ready | output | 1 | Idle, command will be taken |
| grant_vl | output | VLW | Active vector length |
| done | output | 1 | One-cycle completion pulse |
| wr_en | input | 1 | Host word write strobe |
| wr_reg | input | RIDXW | Host write register |
| wr_word | input | WIDXW | Host write word index |
| wr_data | input | 32 | Host write data |
| rd_reg | input | RIDXW | Read register |
| rd_word | input | WIDXW | Read word index |
| rd_data | output | 32 | Read data |

## Verification
Two things can meet in one cycle. The first is a completion pulse together with the acceptance of the next command. The bench issues an add in the very cycle the configure's `done` is seen. It then judges the add's latency and its written elements against the length just granted. The second is a configure and a host write arriving while an add is still stepping through its groups. Here the bench confirms that `cmd_ready` was low, that `grant_vl` kept the old length, and that the written word reads back unchanged. All table cases run on a two-lane and a four-lane instance together, and both are compared with one reference.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } st_e;

  localparam logic       OP_CFG  = 1'b0;
  localparam logic       OP_ADD  = 1'b1;
  localparam logic [1:0] SEW_RSV = 2'd3;

  function automatic int unsigned sew_bits(logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] sew_mask(logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/vls_vl_grant.sv
module vls_vl_grant
  import vls_pkg::*;
#(
  parameter int VLEN = 256,
  parameter int AVLW = 16,
  parameter int VLW  = 6
) (
  input  logic [AVLW-1:0] req_avl,
  input  logic [1:0]      req_sew,
  output logic [VLW-1:0]  grant,
  output logic [1:0]      sew_eff
);

  localparam int MAX_E8  = VLEN / 8;
  localparam int MAX_E16 = VLEN / 16;
  localparam int MAX_E32 = VLEN / 32;

  logic [31:0] vlmax;

  always_comb begin
    case (req_sew)
      2'd0:    vlmax = 32'(MAX_E8);
      2'd1:    vlmax = 32'(MAX_E16);
      2'd2:    vlmax = 32'(MAX_E32);
      default: vlmax = 32'd0;
    endcase
    sew_eff = (req_sew == SEW_RSV) ? 2'd2 : req_sew;
    if (32'(req_avl) > vlmax) grant = VLW'(vlmax);
    else                      grant = VLW'(req_avl);
  end

  // R1: grant never exceeds request or capacity
  always_comb begin
    p_grant_bound_r1: assert (32'(grant) <= 32'(req_avl) && 32'(grant) <= vlmax)
      else $error("grant above request or capacity");
  end

endmodule

// File: rtl/vls_lane.sv
module vls_lane
  import vls_pkg::*;
#(
  parameter int VLW  = 6,
  parameter int IDXW = 7
) (
  input  logic            active,
  input  logic [IDXW-1:0] idx,
  input  logic [VLW-1:0]  vl,
  input  logic [1:0]      sew,
  input  logic [31:0]     op_a,
  input  logic [31:0]     op_b,
  output logic            we,
  output logic [31:0]     sum
);

  logic [31:0] raw;

  always_comb begin
    raw = op_a + op_b;
    sum = raw & sew_mask(sew);
    we  = active && (idx < IDXW'(vl));
  end

endmodule

// File: rtl/vls_vrf.sv
module vls_vrf
  import vls_pkg::*;
#(
  parameter int VLEN  = 256,
  parameter int NREGS = 4,
  parameter int LANES = 2,
  parameter int IDXW  = 7,
  localparam int RIDXW = $clog2(NREGS),
  localparam int WORDS = VLEN / 32,
  localparam int WIDXW = $clog2(WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_we,
  input  logic [RIDXW-1:0]            host_reg,
  input  logic [WIDXW-1:0]            host_word,
  input  logic [31:0]                 host_data,
  input  logic [1:0]                  sew,
  input  logic [RIDXW-1:0]            vd,
  input  logic [RIDXW-1:0]            vs1,
  input  logic [RIDXW-1:0]            vs2,
  input  logic [LANES-1:0][IDXW-1:0]  ln_idx,
  input  logic [LANES-1:0]            ln_we,
  input  logic [LANES-1:0][31:0]      ln_sum,
  output logic [LANES-1:0][31:0]      ln_a,
  output logic [LANES-1:0][31:0]      ln_b,
  input  logic [RIDXW-1:0]            rd_reg,
  input  logic [WIDXW-1:0]            rd_word,
  output logic [31:0]                 rd_data
);

  logic [VLEN-1:0] mem_q [NREGS];
  logic [VLEN-1:0] mem_d [NREGS];
  logic            mem_en;

  function automatic logic [31:0] get_elem(logic [VLEN-1:0] v, logic [IDXW-1:0] i,
                                           logic [1:0] code);
    logic [VLEN-1:0] sh;
    sh = v >> (32'(i) * sew_bits(code));
    return sh[31:0] & sew_mask(code);
  endfunction

  function automatic logic [VLEN-1:0] put_elem(logic [VLEN-1:0] v, logic [IDXW-1:0] i,
                                               logic [1:0] code, logic [31:0] val);
    int unsigned off;
    off = 32'(i) * sew_bits(code);
    return (v & ~(VLEN'(sew_mask(code)) << off)) | (VLEN'(val & sew_mask(code)) << off);
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign ln_a[l] = get_elem(mem_q[vs1], ln_idx[l], sew);
    assign ln_b[l] = get_elem(mem_q[vs2], ln_idx[l], sew);
  end

  always_comb begin
    for (int r = 0; r < NREGS; r++) mem_d[r] = mem_q[r];
    if (host_we) mem_d[host_reg][32*host_word +: 32] = host_data;
    for (int l = 0; l < LANES; l++) begin
      if (ln_we[l]) mem_d[vd] = put_elem(mem_d[vd], ln_idx[l], sew, ln_sum[l]);
    end
    mem_en = host_we || (|ln_we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) mem_q[r] <= '0;
    end else if (mem_en) begin
      for (int r = 0; r < NREGS; r++) mem_q[r] <= mem_d[r];
    end
  end

  assign rd_data = mem_q[rd_reg][32*rd_word +: 32];

  // R9: host write and lane writeback never share a cycle
  p_host_lane_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |-> (ln_we == '0));

endmodule

// File: rtl/vls_seq_top.sv
module vls_seq_top
  import vls_pkg::*;
#(
  parameter int VLEN  = 256,
  parameter int LANES = 2,
  parameter int NREGS = 4,
  parameter int AVLW  = 16,
  localparam int VLW   = $clog2(VLEN / 8) + 1,
  localparam int IDXW  = VLW + 1,
  localparam int RIDXW = $clog2(NREGS),
  localparam int WIDXW = $clog2(VLEN / 32)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_op,
  input  logic [AVLW-1:0]  cmd_avl,
  input  logic [1:0]       cmd_sew,
  input  logic [RIDXW-1:0] cmd_vd,
  input  logic [RIDXW-1:0] cmd_vs1,
  input  logic [RIDXW-1:0] cmd_vs2,
  output logic             cmd_ready,
  output logic [VLW-1:0]   grant_vl,
  output logic             done,
  input  logic             wr_en,
  input  logic [RIDXW-1:0] wr_reg,
  input  logic [WIDXW-1:0] wr_word,
  input  logic [31:0]      wr_data,
  input  logic [RIDXW-1:0] rd_reg,
  input  logic [WIDXW-1:0] rd_word,
  output logic [31:0]      rd_data
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  st_e              state_q, state_d;
  logic [IDXW-1:0]  base_q,  base_d;
  logic [VLW-1:0]   vl_q,    vl_d;
  logic [1:0]       sew_q,   sew_d;
  logic [RIDXW-1:0] vd_q,  vd_d, vs1_q, vs1_d, vs2_q, vs2_d;
  logic             done_q,  done_d;
  logic             accept, ctl_en;

  logic [VLW-1:0]   cfg_grant;
  logic [1:0]       cfg_sew;

  vls_vl_grant #(.VLEN(VLEN), .AVLW(AVLW), .VLW(VLW)) u_grant (
    .req_avl (cmd_avl),
    .req_sew (cmd_sew),
    .grant   (cfg_grant),
    .sew_eff (cfg_sew)
  );

  assign accept = cmd_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    vl_d    = vl_q;
    sew_d   = sew_q;
    vd_d    = vd_q;
    vs1_d   = vs1_q;
    vs2_d   = vs2_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (cmd_op == OP_CFG) begin
            vl_d   = cfg_grant;
            sew_d  = cfg_sew;
            done_d = 1'b1;
          end else begin
            vd_d   = cmd_vd;
            vs1_d  = cmd_vs1;
            vs2_d  = cmd_vs2;
            base_d = '0;
            if (vl_q == '0) done_d  = 1'b1;
            else            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        base_d = base_q + IDXW'(LANES);
        if ((base_q + IDXW'(LANES)) >= IDXW'(vl_q)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    ctl_en = accept || (state_q == ST_RUN) || done_q;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      vl_q    <= '0;
      sew_q   <= '0;
      vd_q    <= '0;
      vs1_q   <= '0;
      vs2_q   <= '0;
      done_q  <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      base_q  <= base_d;
      vl_q    <= vl_d;
      sew_q   <= sew_d;
      vd_q    <= vd_d;
      vs1_q   <= vs1_d;
      vs2_q   <= vs2_d;
      done_q  <= done_d;
    end
  end

  // lanes
  logic [LANES-1:0][IDXW-1:0] ln_idx;
  logic [LANES-1:0]           ln_we;
  logic [LANES-1:0][31:0]     ln_sum, ln_a, ln_b;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign ln_idx[l] = base_q + IDXW'(l);
    vls_lane #(.VLW(VLW), .IDXW(IDXW)) u_lane (
      .active (state_q == ST_RUN),
      .idx    (ln_idx[l]),
      .vl     (vl_q),
      .sew    (sew_q),
      .op_a   (ln_a[l]),
      .op_b   (ln_b[l]),
      .we     (ln_we[l]),
      .sum    (ln_sum[l])
    );
  end

  vls_vrf #(.VLEN(VLEN), .NREGS(NREGS), .LANES(LANES), .IDXW(IDXW)) u_vrf (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .host_we   (wr_en && (state_q == ST_IDLE)),
    .host_reg  (wr_reg),
    .host_word (wr_word),
    .host_data (wr_data),
    .sew       (sew_q),
    .vd        (vd_q),
    .vs1       (vs1_q),
    .vs2       (vs2_q),
    .ln_idx    (ln_idx),
    .ln_we     (ln_we),
    .ln_sum    (ln_sum),
    .ln_a      (ln_a),
    .ln_b      (ln_b),
    .rd_reg    (rd_reg),
    .rd_word   (rd_word),
    .rd_data   (rd_data)
  );

  assign cmd_ready = (state_q == ST_IDLE);
  assign grant_vl  = vl_q;
  assign done      = done_q;

  // R2: stored length always fits the stored width
  p_vl_fits_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (32'(vl_q) * sew_bits(sew_q)) <= VLEN);

  // R4: running groups start below the active length
  p_base_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (state_q == ST_RUN) |-> (base_q < IDXW'(vl_q)));

  // R8: a command while running leaves the length alone
  p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmd_valid && state_q == ST_RUN) |=> $stable(vl_q));

  // R7: no done before the last group
  p_no_early_done_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (state_q == ST_RUN && (32'(base_q) + LANES) < 32'(vl_q)) |=> !done_q);

  // R5: leaving the run state always reports completion
  p_run_ends_done_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(state_q == ST_RUN) |-> done_q);

endmodule

// File: tb/vls_seq_top_tb_top.sv
`timescale 1ns/1ps
module vls_seq_top_tb_top;

  localparam int VLEN = 256;
  localparam int WORDS = VLEN / 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_op;
  logic [15:0] cmd_avl;
  logic [1:0]  cmd_sew, cmd_vd, cmd_vs1, cmd_vs2;
  logic        wr_en;
  logic [1:0]  wr_reg;
  logic [2:0]  wr_word, rd_word;
  logic [31:0] wr_data;
  logic [1:0]  rd_reg;

  logic        ready_a, ready_b, done_a, done_b;
  logic [5:0]  grant_a, grant_b;
  logic [31:0] rd_a, rd_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vls_seq_top #(.VLEN(VLEN), .LANES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_avl(cmd_avl), .cmd_sew(cmd_sew), .cmd_vd(cmd_vd), .cmd_vs1(cmd_vs1),
    .cmd_vs2(cmd_vs2), .cmd_ready(ready_a), .grant_vl(grant_a), .done(done_a),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_word(wr_word), .wr_data(wr_data),
    .rd_reg(rd_reg), .rd_word(rd_word), .rd_data(rd_a)
  );

  vls_seq_top #(.VLEN(VLEN), .LANES(4)) dut4_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_avl(cmd_avl), .cmd_sew(cmd_sew), .cmd_vd(cmd_vd), .cmd_vs1(cmd_vs1),
    .cmd_vs2(cmd_vs2), .cmd_ready(ready_b), .grant_vl(grant_b), .done(done_b),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_word(wr_word), .wr_data(wr_data),
    .rd_reg(rd_reg), .rd_word(rd_word), .rd_data(rd_b)
  );

  // table: {sew code, requested count, expected grant}
  localparam int NT = 9;
  localparam logic [23:0] TBL [NT] = '{
    {2'd1, 16'd8,     6'd8},
    {2'd1, 16'd40,    6'd16},
    {2'd0, 16'd32,    6'd32},
    {2'd0, 16'd7,     6'd7},
    {2'd2, 16'd5,     6'd5},
    {2'd2, 16'd100,   6'd8},
    {2'd1, 16'd0,     6'd0},
    {2'd0, 16'd65535, 6'd32},
    {2'd3, 16'd4,     6'd0}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bits_of(logic [1:0] c);
    return (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] pat(int t, int r, int w);
    if (t == 2) return 32'hFFFF_FFFF;
    return 32'h9E37_79B9 * 32'(t * 24 + r * 8 + w + 1) ^ 32'(r * 32'h0101_0101);
  endfunction

  function automatic logic [VLEN-1:0] ref_add(logic [VLEN-1:0] va, logic [VLEN-1:0] vb,
                                              logic [VLEN-1:0] vs, int g, int b);
    logic [VLEN-1:0] r;
    r = vs;
    for (int i = 0; i < g; i++) begin
      logic [31:0] m;
      logic [31:0] s;
      m = (b == 32) ? 32'hFFFF_FFFF : ((32'd1 << b) - 32'd1);
      s = (32'(va >> (i * b)) + 32'(vb >> (i * b))) & m;
      r = (r & ~(VLEN'(m) << (i * b))) | (VLEN'(s) << (i * b));
    end
    return r;
  endfunction

  task automatic host_write(input logic [1:0] r, input int w, input logic [31:0] d);
    wr_en = 1'b1; wr_reg = r; wr_word = 3'(w); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  // command already driven at a negedge; counts edges after acceptance
  task automatic run_cmd(input int lat_a, input int lat_b, input string req);
    int seen_a = -1, seen_b = -1, cnt_a = 0, cnt_b = 0;
    for (int k = 0; k < 64; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 0) cmd_valid = 1'b0;
      if (done_a) begin cnt_a++; if (seen_a < 0) seen_a = k; end
      if (done_b) begin cnt_b++; if (seen_b < 0) seen_b = k; end
      if (k > lat_a && k > lat_b) break;
    end
    check(seen_a == lat_a, {req, " latency L2"}, seen_a, lat_a);
    check(seen_b == lat_b, {req, " latency L4"}, seen_b, lat_b);
    check(cnt_a == 1 && cnt_b == 1, "R7 single done pulse", {cnt_a, cnt_b}, {1, 1});
  endtask

  task automatic drive_cfg(input logic [1:0] s, input logic [15:0] n);
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_sew = s; cmd_avl = n;
  endtask

  task automatic drive_add(input logic [1:0] d, input logic [1:0] a, input logic [1:0] b);
    cmd_valid = 1'b1; cmd_op = 1'b1; cmd_vd = d; cmd_vs1 = a; cmd_vs2 = b;
  endtask

  task automatic compare_reg(input logic [1:0] r, input logic [VLEN-1:0] exp, input string req);
    for (int w = 0; w < WORDS; w++) begin
      rd_reg = r; rd_word = 3'(w);
      #1;
      check(rd_a == exp[32*w +: 32], {req, " L2 word"}, rd_a, exp[32*w +: 32]);
      check(rd_b == rd_a, "R12 lane-count independence", rd_b, rd_a);
    end
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] va, vb, vs, ve;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 1'b0; cmd_avl = '0; cmd_sew = '0;
    cmd_vd = '0; cmd_vs1 = '0; cmd_vs2 = '0; wr_en = 1'b0; wr_reg = '0;
    wr_word = '0; wr_data = '0; rd_reg = '0; rd_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check(ready_a && ready_b, "R10 ready", {ready_a, ready_b}, 2'b11);
    check(!done_a && !done_b, "R10 done", {done_a, done_b}, 0);
    check(grant_a == 0 && grant_b == 0, "R10 grant", grant_a, 0);
    compare_reg(2'd1, '0, "R10 regs");

    // table walk
    for (int t = 0; t < NT; t++) begin
      logic [1:0] s;
      int g;
      string rq;
      s = TBL[t][23:22];
      g = int'(TBL[t][5:0]);
      rq = (s == 2'd3) ? "R2" : "R1";
      drive_cfg(s, TBL[t][21:6]);
      run_cmd(0, 0, "R5 cfg");
      check(grant_a == 6'(g) && grant_b == 6'(g), {rq, " grant"}, grant_a, g);
      for (int w = 0; w < WORDS; w++) begin
        va[32*w +: 32] = pat(t, 1, w);
        vb[32*w +: 32] = pat(t, 2, w);
        vs[32*w +: 32] = 32'hA5A5_A5A5;
        host_write(2'd1, w, va[32*w +: 32]);
        host_write(2'd2, w, vb[32*w +: 32]);
        host_write(2'd3, w, vs[32*w +: 32]);
      end
      ve = ref_add(va, vb, vs, g, bits_of(s));
      drive_add(2'd3, 2'd1, 2'd2);
      run_cmd((g + 1) / 2, (g + 3) / 4, (g == 0) ? "R6 R5 add" : "R5 add");
      compare_reg(2'd3, ve, (g == 0) ? "R6 no write" : "R3 R4 result");
    end

    // R11 back-to-back: add issued in the configure's done cycle
    drive_cfg(2'd1, 16'd6);
    @(posedge clk); @(negedge clk);
    check(done_a && done_b && ready_a && ready_b, "R11 done with ready", {done_a, done_b}, 2'b11);
    for (int w = 0; w < WORDS; w++) begin
      va[32*w +: 32] = pat(11, 1, w);
      vb[32*w +: 32] = pat(11, 2, w);
      vs[32*w +: 32] = 32'h0F0F_0F0F;
    end
    ve = ref_add(va, vb, vs, 6, 16);
    drive_add(2'd3, 2'd1, 2'd2);
    run_cmd(3, 2, "R11 add");
    check(grant_a == 6, "R11 grant", grant_a, 6);
    // results compared after loading fresh operands and re-running
    for (int w = 0; w < WORDS; w++) begin
      host_write(2'd1, w, va[32*w +: 32]);
      host_write(2'd2, w, vb[32*w +: 32]);
      host_write(2'd3, w, vs[32*w +: 32]);
    end
    drive_add(2'd3, 2'd1, 2'd2);
    run_cmd(3, 2, "R5 add six");
    compare_reg(2'd3, ve, "R4 R11 partial");

    // R8 / R9: configure and host write while running
    drive_cfg(2'd1, 16'd16);
    run_cmd(0, 0, "R5 cfg");
    drive_add(2'd3, 2'd1, 2'd2);
    @(posedge clk); @(negedge clk);
    check(!ready_a && !ready_b, "R8 ready low while running", {ready_a, ready_b}, 0);
    cmd_op = 1'b0; cmd_sew = 2'd0; cmd_avl = 16'd3;
    wr_en = 1'b1; wr_reg = 2'd0; wr_word = 3'd0; wr_data = 32'hDEAD_BEEF;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; wr_en = 1'b0;
    repeat (12) @(negedge clk);
    check(grant_a == 16 && grant_b == 16, "R8 grant kept", grant_a, 16);
    rd_reg = 2'd0; rd_word = 3'd0; #1;
    check(rd_a == 0 && rd_b == 0, "R9 busy write ignored", rd_a, 0);

    // R9 idle host write lands
    host_write(2'd0, 5, 32'h1234_5678);
    rd_reg = 2'd0; rd_word = 3'd5; #1;
    check(rd_a == 32'h1234_5678 && rd_b == rd_a, "R9 idle write", rd_a, 32'h1234_5678);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule